// File: doc/BRIEF.md
# Internal Data Memory and Address Decoder

This block is the on-chip data store of an 8-bit microcontroller core. It holds 128 bytes of RAM and a 128-location window of special function registers (SFRs). Each cycle the core presents one request: an 8-bit address, an operation code, a write enable, a write byte and a single write bit. The block resolves the address according to the operation, performs any write at the clock edge, and returns the addressed contents one cycle later on a registered read port.

The same 8-bit address means different things in different modes. A direct access above 7FH reaches the SFR window. An indirect access above 7FH reaches nothing. A register operand is moved into one of four 8-byte banks by two bank bits held in the status SFR. A bit operand picks a single bit either from the bit-addressable RAM bytes or from SFRs whose addresses end in 0H or 8H. A bit write is a read-modify-write of the containing byte, done within the request cycle. The stack pointer is an SFR that push and pop operations step.

Top module: `idata_unit`

## Requirements
- R1: Operation codes are: 0 idle, 1 direct, 2 indirect, 3 register, 4 bit, 5 push, 6 pop, and 7 is treated as idle. Direct and indirect accesses with addresses 00H–7FH read and write the RAM byte at that address. The read value appears on rd_data in the cycle after the request.
- R2: A direct access with an address of 80H–FFH reads and writes the SFR at that address. The stack pointer sits at 81H and the status register at D0H, and every other SFR location holds its written byte.
- R3: An indirect access with an address of 80H or above returns 00H, and its write has no effect on any RAM byte or SFR.
- R4: A register access to operand n (address bits [2:0]) uses RAM address 8*bank + n. The bank is bits [4:3] of the status SFR at D0H.
- R5: After reset, rd_data is 00H, the stack pointer is 07H and every other SFR, including the status register, is 00H. This selects bank 0.
- R6: A bit access with bit address b below 80H reaches RAM byte 20H + b[6:3], bit b[2:0]. A bit read returns that bit on rd_data[0], with rd_data[7:1] zero.
- R7: A bit access with b of 80H or above reaches bit b[2:0] of the SFR at address b with bits [2:0] cleared.
- R8: A bit write sets the addressed bit to wr_bit and leaves the other seven bits of the byte unchanged.
- R9: A push first adds 1 to the stack pointer, modulo 256. It then writes wr_data to the RAM byte at the new value, and rd_data becomes 00H. If the new value is 80H or above, the data write is dropped.
- R10: A pop returns the byte at the current stack pointer, read in the same way as an indirect access, and then subtracts 1 from the stack pointer, modulo 256.
- R11: An idle cycle leaves rd_data and all stored state unchanged.
- R12: A request that reads and writes the same location in one cycle returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code of the request |
| addr | input | 8 | Byte, bit or register-operand address |
| wr_en | input | 1 | Write request for direct, indirect, register and bit operations |
| wr_data | input | 8 | Byte to write, also the push data |
| wr_bit | input | 1 | Bit value for bit writes |
| rd_data | output | 8 | Registered read result |

## Verification
Every request is sampled on a rising edge. Its write, stack-pointer step and rd_data update all land on that same edge, so the result is due one cycle after the request and a following request already sees the new state. The bench drives each request on a falling edge and advances its behavioural model at the rising edge. It then compares rd_data against the model on the next falling edge, so every comparison falls in the cycle in which the result is due. Bank switches, bit merges and stack-pointer steps are checked indirectly, by later reads that return the state those operations changed.

// File: rtl/idm_pkg.sv
`timescale 1ns/1ps
package idm_pkg;
  localparam int BYTE_W = 8;
  localparam int WIN_AW = 7;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_DIR  = 3'd1,
    OP_IND  = 3'd2,
    OP_REG  = 3'd3,
    OP_BIT  = 3'd4,
    OP_PUSH = 3'd5,
    OP_POP  = 3'd6,
    OP_RSVD = 3'd7
  } op_e;

  typedef struct packed {
    logic              hit_ram;
    logic              hit_sfr;
    logic              is_bit;
    logic [WIN_AW-1:0] idx;
    logic [2:0]        bpos;
  } target_t;
endpackage

// File: rtl/idm_decode.sv
`timescale 1ns/1ps
module idm_decode
  import idm_pkg::*;
#(
  parameter int RAM_BYTES = 128
) (
  input  logic [2:0]        op,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] sp,
  input  logic [1:0]        bank,
  output target_t           tgt,
  output logic              sp_upd,
  output logic [BYTE_W-1:0] sp_nxt
);
  logic [BYTE_W-1:0] sp_up;
  logic [BYTE_W-1:0] sp_dn;

  assign sp_up = sp + 8'd1;
  assign sp_dn = sp - 8'd1;

  always_comb begin
    tgt    = '0;
    sp_upd = 1'b0;
    sp_nxt = sp;
    unique case (op_e'(op))
      OP_DIR: begin
        if (!addr[7]) tgt.hit_ram = (int'(addr) < RAM_BYTES);
        else          tgt.hit_sfr = 1'b1;
        tgt.idx = addr[6:0];
      end
      OP_IND: begin
        tgt.hit_ram = !addr[7] && (int'(addr) < RAM_BYTES);
        tgt.idx     = addr[6:0];
      end
      OP_REG: begin
        tgt.hit_ram = 1'b1;
        tgt.idx     = {2'b00, bank, addr[2:0]};
      end
      OP_BIT: begin
        tgt.is_bit = 1'b1;
        tgt.bpos   = addr[2:0];
        if (!addr[7]) begin
          tgt.hit_ram = 1'b1;
          tgt.idx     = {3'b010, addr[6:3]};
        end else begin
          tgt.hit_sfr = 1'b1;
          tgt.idx     = {addr[6:3], 3'b000};
        end
      end
      OP_PUSH: begin
        tgt.hit_ram = !sp_up[7] && (int'(sp_up) < RAM_BYTES);
        tgt.idx     = sp_up[6:0];
        sp_upd      = 1'b1;
        sp_nxt      = sp_up;
      end
      OP_POP: begin
        tgt.hit_ram = !sp[7] && (int'(sp) < RAM_BYTES);
        tgt.idx     = sp[6:0];
        sp_upd      = 1'b1;
        sp_nxt      = sp_dn;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idm_ram.sv
`timescale 1ns/1ps
module idm_ram
  import idm_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/idm_sfr.sv
`timescale 1ns/1ps
module idm_sfr
  import idm_pkg::*;
#(
  parameter logic [WIN_AW-1:0] SP_IDX  = 7'h01,
  parameter logic [WIN_AW-1:0] PSW_IDX = 7'h50,
  parameter logic [BYTE_W-1:0] SP_INIT = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WIN_AW-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [WIN_AW-1:0] raddr,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] sp_o,
  output logic [BYTE_W-1:0] psw_o
);
  localparam int N = 1 << WIN_AW;
  logic [BYTE_W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam logic [BYTE_W-1:0] INIT = (i == int'(SP_IDX)) ? SP_INIT : '0;
    always_ff @(posedge clk) begin
      if (rst)                                  regs[i] <= INIT;
      else if (we && waddr == WIN_AW'(i))       regs[i] <= wdata;
    end
  end

  assign rdata = regs[raddr];
  assign sp_o  = regs[SP_IDX];
  assign psw_o = regs[PSW_IDX];
endmodule

// File: rtl/idata_unit.sv
`timescale 1ns/1ps
module idata_unit
  import idm_pkg::*;
#(
  parameter int                RAM_BYTES = 128,
  parameter logic [BYTE_W-1:0] SP_RESET  = 8'h07,
  parameter logic [BYTE_W-1:0] SP_LOC    = 8'h81,
  parameter logic [BYTE_W-1:0] PSW_LOC   = 8'hD0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op,
  input  logic [7:0]        addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              wr_bit,
  output logic [7:0]        rd_data
);
  localparam logic [WIN_AW-1:0] SP_IDX  = SP_LOC[WIN_AW-1:0];
  localparam logic [WIN_AW-1:0] PSW_IDX = PSW_LOC[WIN_AW-1:0];
  localparam int                RAM_AW  = $clog2(RAM_BYTES);

  target_t           tgt;
  logic              sp_upd;
  logic [BYTE_W-1:0] sp_nxt, sp_w, psw_w;
  logic [BYTE_W-1:0] ram_q, sfr_q, cur_byte, new_byte;
  logic              is_access, do_write, ram_we, sfr_we;
  logic [WIN_AW-1:0] sfr_waddr;
  logic [BYTE_W-1:0] sfr_wdata;
  op_e               op_t;

  assign op_t = op_e'(op);

  idm_decode #(.RAM_BYTES(RAM_BYTES)) dec_i (
    .op(op), .addr(addr), .sp(sp_w), .bank(psw_w[4:3]),
    .tgt(tgt), .sp_upd(sp_upd), .sp_nxt(sp_nxt)
  );

  idm_ram #(.DEPTH(RAM_BYTES)) ram_i (
    .clk(clk), .we(ram_we), .waddr(tgt.idx[RAM_AW-1:0]), .wdata(new_byte),
    .raddr(tgt.idx[RAM_AW-1:0]), .rdata(ram_q)
  );

  idm_sfr #(.SP_IDX(SP_IDX), .PSW_IDX(PSW_IDX), .SP_INIT(SP_RESET)) sfr_i (
    .clk(clk), .rst(rst), .we(sfr_we), .waddr(sfr_waddr), .wdata(sfr_wdata),
    .raddr(tgt.idx), .rdata(sfr_q), .sp_o(sp_w), .psw_o(psw_w)
  );

  always_comb begin
    cur_byte = tgt.hit_ram ? ram_q : (tgt.hit_sfr ? sfr_q : 8'h00);
    new_byte = wr_data;
    if (tgt.is_bit) begin
      new_byte            = cur_byte;
      new_byte[tgt.bpos]  = wr_bit;
    end
  end

  assign is_access = (op_t == OP_DIR) || (op_t == OP_IND) ||
                     (op_t == OP_REG) || (op_t == OP_BIT);
  assign do_write  = (is_access && wr_en) || (op_t == OP_PUSH);
  assign ram_we    = do_write && tgt.hit_ram && !rst;
  assign sfr_we    = ((do_write && tgt.hit_sfr) || sp_upd) && !rst;
  assign sfr_waddr = sp_upd ? SP_IDX : tgt.idx;
  assign sfr_wdata = sp_upd ? sp_nxt : new_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else if (is_access || op_t == OP_POP) begin
      rd_data <= tgt.is_bit ? {7'b0, cur_byte[tgt.bpos]} : cur_byte;
    end else if (op_t == OP_PUSH) begin
      rd_data <= 8'h00;
    end
  end

  // R5: stack pointer comes out of reset at its initial value
  a_r5_sp_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sp_w == SP_RESET && psw_w == 8'h00));

  // R9: push pre-increments the stack pointer
  a_r9_push_step: assert property (@(posedge clk) disable iff (rst)
    (op_t == OP_PUSH) |=> (sp_w == $past(sp_w) + 8'd1));

  // R10: pop post-decrements the stack pointer
  a_r10_pop_step: assert property (@(posedge clk) disable iff (rst)
    (op_t == OP_POP) |=> (sp_w == $past(sp_w) - 8'd1));

  // R11: idle keeps the read port steady
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (op_t == OP_IDLE || op_t == OP_RSVD) |=> $stable(rd_data));

  // R3: high indirect accesses never write storage
  a_r3_ind_high_nowrite: assert property (@(posedge clk) disable iff (rst)
    (op_t == OP_IND && addr[7]) |-> (!ram_we && !sfr_we));

  // R6: bit reads return a single bit
  a_r6_bit_narrow: assert property (@(posedge clk) disable iff (rst)
    (op_t == OP_BIT) |=> (rd_data[7:1] == 7'd0));

  // R4: register operands land in the bank chosen by the status bits
  a_r4_reg_bank: assert property (@(posedge clk) disable iff (rst)
    (op_t == OP_REG) |-> (tgt.hit_ram && tgt.idx[4:3] == psw_w[4:3] &&
                          tgt.idx[6:5] == 2'b00));
endmodule

// File: tb/idata_unit_tb.sv
`timescale 1ns/1ps
module idata_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op = 3'd0;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_bit = 1'b0;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int m_ram [128];
  int m_sfr [128];
  int m_rd = 0;

  idata_unit dut_i (
    .clk(clk), .rst(rst), .op(op), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .wr_bit(wr_bit), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // One request: drive on a falling edge, step the model at the rising edge,
  // compare rd_data on the following falling edge.
  task automatic step(input int o, input int a, input bit we, input int wd,
                      input bit bv, input string tag, input bit chk);
    int sp, bank, cur, nb, ix, bp;
    bit tr, ts, isb;
    op = 3'(o); addr = 8'(a); wr_en = we; wr_data = 8'(wd); wr_bit = bv;
    sp = m_sfr[1]; bank = (m_sfr[8'h50] >> 3) & 3;
    tr = 0; ts = 0; isb = 0; ix = 0; bp = 0;
    case (o)
      1: begin if (a < 128) tr = 1; else ts = 1; ix = a % 128; end
      2: begin if (a < 128) begin tr = 1; ix = a; end end
      3: begin tr = 1; ix = bank * 8 + (a % 8); end
      4: begin
        isb = 1; bp = a % 8;
        if (a < 128) begin tr = 1; ix = 32 + a / 8; end
        else begin ts = 1; ix = (a & 248) - 128; end
      end
      5: begin sp = (sp + 1) % 256; if (sp < 128) begin tr = 1; ix = sp; end end
      6: begin if (sp < 128) begin tr = 1; ix = sp; end end
      default: ;
    endcase
    cur = tr ? m_ram[ix] : (ts ? m_sfr[ix] : 0);
    if (o >= 1 && o <= 4 || o == 6) m_rd = isb ? (cur >> bp) & 1 : cur;
    else if (o == 5) m_rd = 0;
    if ((o >= 1 && o <= 4 && we) || o == 5) begin
      nb = isb ? ((cur & ~(1 << bp)) | (int'(bv) << bp)) : wd;
      if (tr) m_ram[ix] = nb;
      if (ts) m_sfr[ix] = nb;
    end
    if (o == 5) m_sfr[1] = sp;
    if (o == 6) m_sfr[1] = (sp + 255) % 256;
    @(posedge clk);
    @(negedge clk);
    if (chk) check(tag, int'(rd_data), m_rd);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    foreach (m_ram[i]) m_ram[i] = 0;
    foreach (m_sfr[i]) m_sfr[i] = 0;
    m_sfr[1] = 8'h07;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R5 rd_data after reset", int'(rd_data), 0);
    step(1, 8'h81, 0, 0, 0, "R5 stack pointer reset", 1);
    step(1, 8'hD0, 0, 0, 0, "R5 status reset", 1);
    step(1, 8'hB8, 0, 0, 0, "R5 other SFR reset", 1);
    for (int i = 0; i < 128; i++) step(1, i, 1, (i * 37 + 5) % 256, 0, "init", 0);

    step(1, 8'h40, 0, 0, 0, "R1 direct read", 1);
    step(2, 8'h55, 1, 8'hC3, 0, "R12 read before write", 1);
    step(2, 8'h55, 0, 0, 0, "R1 indirect readback", 1);
    step(1, 8'h55, 0, 0, 0, "R1 direct sees indirect write", 1);

    step(1, 8'h90, 1, 8'hA5, 0, "R2 SFR write", 1);
    step(1, 8'h90, 0, 0, 0, "R2 SFR readback", 1);
    step(2, 8'h90, 1, 8'h3C, 0, "R3 indirect high write", 1);
    step(2, 8'h90, 0, 0, 0, "R3 indirect high reads zero", 1);
    step(1, 8'h90, 0, 0, 0, "R3 SFR untouched", 1);

    step(3, 2, 1, 8'h11, 0, "R4 bank0 write", 1);
    step(1, 8'h02, 0, 0, 0, "R4 bank0 at 02H", 1);
    step(1, 8'hD0, 1, 8'h18, 0, "R4 select bank3", 1);
    step(3, 2, 1, 8'h22, 0, "R4 bank3 write", 1);
    step(1, 8'h1A, 0, 0, 0, "R4 bank3 at 1AH", 1);
    step(4, 8'hD4, 1, 0, 1, "R7 status bit4 set", 1);
    step(1, 8'hD0, 0, 0, 0, "R7 status now 18H", 1);
    step(4, 8'hD4, 1, 0, 0, "R7 status bit4 clear", 1);
    step(3, 5, 0, 0, 0, "R4 bank1 read 0DH", 1);
    step(1, 8'hD0, 1, 8'h00, 0, "R4 back to bank0", 1);

    step(1, 8'h21, 1, 8'hF0, 0, "R8 seed byte 21H", 1);
    step(4, 8'h0B, 1, 0, 1, "R8 bit write 0BH", 1);
    step(1, 8'h21, 0, 0, 0, "R8 byte 21H other bits kept", 1);
    step(4, 8'h0C, 1, 0, 0, "R8 clear bit 0CH", 1);
    step(1, 8'h21, 0, 0, 0, "R8 byte 21H after clear", 1);
    step(4, 8'h0B, 0, 0, 0, "R6 bit read", 1);
    step(4, 8'h7F, 0, 0, 0, "R6 top RAM bit", 1);
    step(4, 8'h93, 1, 0, 0, "R7 SFR bit clear", 1);
    step(1, 8'h90, 0, 0, 0, "R7 SFR byte after bit", 1);

    step(5, 0, 0, 8'h6D, 0, "R9 push", 1);
    step(1, 8'h81, 0, 0, 0, "R9 pointer 08H", 1);
    step(1, 8'h08, 0, 0, 0, "R9 pushed byte", 1);
    step(6, 0, 0, 0, 0, "R10 pop", 1);
    step(1, 8'h81, 0, 0, 0, "R10 pointer back", 1);
    step(1, 8'h81, 1, 8'h00, 0, "R10 pointer to 00H", 1);
    step(6, 0, 0, 0, 0, "R10 pop at 00H", 1);
    step(1, 8'h81, 0, 0, 0, "R10 wrap to FFH", 1);
    step(1, 8'h81, 1, 8'h7F, 0, "R9 pointer to 7FH", 1);
    step(5, 0, 0, 8'hEE, 0, "R9 push above RAM", 1);
    step(6, 0, 0, 0, 0, "R10 pop above RAM", 1);
    step(1, 8'h7F, 0, 0, 0, "R9 top RAM intact", 1);

    step(1, 8'h33, 0, 0, 0, "R11 load", 1);
    step(0, 8'h44, 1, 8'h99, 0, "R11 idle hold", 1);
    step(7, 8'h44, 1, 8'h99, 0, "R11 reserved hold", 1);
    step(1, 8'h44, 0, 0, 0, "R11 nothing written", 1);

    for (int k = 0; k < 3000; k++) begin
      int o;
      o = int'($urandom_range(0, 7));
      step(o, int'($urandom_range(0, 255)), 1'($urandom), int'($urandom_range(0, 255)),
           1'($urandom), "R1 R2 R12 mixed", 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule